// File: doc/BRIEF.md
# Cache Maintenance Operation Engine

This engine works next to a small direct-mapped write-back data cache and runs maintenance commands on it. Each command has a 2-bit opcode, an address and a data word. The address and data are used only by the per-line commands. There are two whole-cache commands. One drops every line and loses any modified data. The other first copies every modified line out to memory and then drops it. There are also two per-line commands: flushing the line that holds a given address, and a non-temporal store that sends a word straight to memory without allocating a line.

The engine reads the cache's valid, dirty, tag and data arrays through a combinational read port that it indexes. It clears a line's valid and dirty bits through a single clear strobe, and it sends line write-backs over a valid/ready memory write port. After either whole-cache command it drives a 2-bit special-cycle code that tells any cache further down to take the same action. While a command is running, the engine holds its command-ready output low and reports busy. When the command is finished it gives a one-cycle done pulse. A cache-disable input turns ordinary cache lookups off. It is meant to be changed only after a full write-back-and-drop.

A cache line holds one data word. The memory address of a line is its tag concatenated above its set index.

Top module: `cache_maint_engine`

## Requirements
- R1: Opcode 00 (drop-all) clears the valid bit of every set and issues no memory write, even for sets marked dirty.
- R2: After the last set has been dropped, opcode 00 drives the special-cycle code 01 for exactly one cycle. The done pulse follows in the next cycle.
- R3: Opcode 01 (write-back-and-drop) writes each valid dirty set to memory at address {tag, index} with its data, in ascending index order. No set is cleared before its write has been accepted. Clean sets are never written. At the end, every set is invalid.
- R4: After the walk, opcode 01 drives the special-cycle code 10 for SPC_CNT consecutive cycles (SPC_CNT is 1 or 2). The done pulse follows the last of those cycles.
- R5: The walk takes one cycle per clean set and one extra cycle per dirty set while memory is ready. With 8 sets, busy lasts 9 cycles for opcode 00 and 8 + dirty + SPC_CNT cycles for opcode 01.
- R6: Opcode 10 (line flush) acts only on the set selected by the address. A valid dirty tag match is written back and then cleared. A valid clean match is cleared with no write. A miss changes nothing and writes nothing.
- R7: Opcode 11 (non-temporal store) writes the command data to the command address exactly once and never allocates a line. On a valid tag match the set is invalidated with no separate write of its old data. On a miss the set is left unchanged.
- R8: While the memory write valid is high and ready is low, the valid, address and data are held stable.
- R9: Command ready is low and busy is high while a command runs. Commands offered during that time have no effect. Done is a single-cycle pulse, and it coincides with busy falling.
- R10: The lookup-permit output is high only when the engine is idle and cache-disable is low.
- R11: The special-cycle code is 00 except during the special cycles of a whole-cache command. The line commands emit none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_op | input | 2 | 00 drop-all, 01 write-back-and-drop, 10 line flush, 11 non-temporal store |
| cmd_addr | input | TAG_W+IDX_W | Word address {tag, index} for line commands |
| cmd_data | input | DATA_W | Store data for opcode 11 |
| arr_idx | output | IDX_W | Set index read from the cache arrays |
| arr_valid | input | 1 | Valid bit of set arr_idx |
| arr_dirty | input | 1 | Dirty bit of set arr_idx |
| arr_tag | input | TAG_W | Tag of set arr_idx |
| arr_data | input | DATA_W | Data word of set arr_idx |
| arr_clr | output | 1 | Clear valid and dirty of set arr_idx at the clock edge |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | TAG_W+IDX_W | Memory write address |
| mem_data | output | DATA_W | Memory write data |
| spc_code | output | 2 | Special cycle: 01 drop, 10 write back and drop, 00 none |
| cache_dis | input | 1 | Cache disable |
| lookup_ok | output | 1 | Normal lookups allowed |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
If the walk index goes wrong, a write-back leaves with the wrong address or out of ascending order, or a set is still valid at the end. This shows up at the first dirty set that is affected, or in the array state once done has pulsed. If the opcode is held wrong, the special-cycle code, the number of special cycles, or the presence of memory writes is wrong within the same command. If a hit decision goes wrong in a line command, a neighbouring line changes, or a write appears or goes missing, within two or three cycles of accepting the command. A stuck sequencer count shows up as an extra or a missing special cycle, or as a shifted busy length.

// File: rtl/cme_pkg.sv
package cme_pkg;
    typedef enum logic [1:0] {
        OP_INV_ALL  = 2'b00,
        OP_WB_INV   = 2'b01,
        OP_FLUSH    = 2'b10,
        OP_NT_STORE = 2'b11
    } cme_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WALK,
        ST_LINE,
        ST_WB,
        ST_SPC
    } cme_st_e;

    localparam logic [1:0] SPC_NONE  = 2'b00;
    localparam logic [1:0] SPC_INV   = 2'b01;
    localparam logic [1:0] SPC_WBINV = 2'b10;
endpackage

// File: rtl/cme_hit.sv
module cme_hit #(
    parameter int TAG_W = 5
) (
    input  logic             valid,
    input  logic             dirty,
    input  logic [TAG_W-1:0] tag_arr,
    input  logic [TAG_W-1:0] tag_ref,
    output logic             hit,
    output logic             hit_dirty
);
    always_comb begin
        hit       = valid && (tag_arr == tag_ref);
        hit_dirty = hit && dirty;
    end
endmodule

// File: rtl/cme_spc_seq.sv
module cme_spc_seq
    import cme_pkg::*;
#(
    parameter int SPC_CNT = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       wb_kind,
    output logic [1:0] spc_code,
    output logic       last
);
    localparam int CNT_W = $clog2(SPC_CNT + 1);
    localparam logic [CNT_W-1:0] LAST_WB = CNT_W'(SPC_CNT - 1);

    typedef struct packed {
        logic             act;
        logic             kind;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d    = seq_q;
        spc_code = seq_q.act ? (seq_q.kind ? SPC_WBINV : SPC_INV) : SPC_NONE;
        last     = seq_q.act && (seq_q.cnt == (seq_q.kind ? LAST_WB : '0));
        if (start) begin
            seq_d.act  = 1'b1;
            seq_d.kind = wb_kind;
            seq_d.cnt  = '0;
        end else if (seq_q.act) begin
            if (last) seq_d.act = 1'b0;
            else      seq_d.cnt = seq_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    AST_SPC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(spc_code)); // R11
    AST_SPC_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.act |-> !start); // R4
endmodule

// File: rtl/cache_maint_engine.sv
module cache_maint_engine
    import cme_pkg::*;
#(
    parameter int IDX_W   = 3,
    parameter int TAG_W   = 5,
    parameter int DATA_W  = 16,
    parameter int SPC_CNT = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_valid,
    output logic                   cmd_ready,
    input  logic [1:0]             cmd_op,
    input  logic [TAG_W+IDX_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0]      cmd_data,
    output logic [IDX_W-1:0]       arr_idx,
    input  logic                   arr_valid,
    input  logic                   arr_dirty,
    input  logic [TAG_W-1:0]       arr_tag,
    input  logic [DATA_W-1:0]      arr_data,
    output logic                   arr_clr,
    output logic                   mem_valid,
    input  logic                   mem_ready,
    output logic [TAG_W+IDX_W-1:0] mem_addr,
    output logic [DATA_W-1:0]      mem_data,
    output logic [1:0]             spc_code,
    input  logic                   cache_dis,
    output logic                   lookup_ok,
    output logic                   busy,
    output logic                   done
);
    localparam int ADDR_W = TAG_W + IDX_W;
    localparam logic [IDX_W-1:0] LAST_IDX = '1;

    typedef struct packed {
        cme_st_e           st;
        cme_op_e           op;
        logic [IDX_W-1:0]  idx;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] sdata;
        logic [ADDR_W-1:0] maddr;
        logic [DATA_W-1:0] mdata;
        logic              done;
    } eng_t;

    eng_t eng_d, eng_q;

    logic line_hit, line_hit_dirty;
    logic spc_start, spc_wb, spc_last;
    logic adv;

    cme_hit #(.TAG_W(TAG_W)) i_hit (
        .valid     (arr_valid),
        .dirty     (arr_dirty),
        .tag_arr   (arr_tag),
        .tag_ref   (eng_q.tag),
        .hit       (line_hit),
        .hit_dirty (line_hit_dirty)
    );

    cme_spc_seq #(.SPC_CNT(SPC_CNT)) i_spc (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (spc_start),
        .wb_kind  (spc_wb),
        .spc_code (spc_code),
        .last     (spc_last)
    );

    always_comb begin
        eng_d      = eng_q;
        eng_d.done = 1'b0;
        arr_clr    = 1'b0;
        spc_start  = 1'b0;
        spc_wb     = 1'b0;
        adv        = 1'b0;
        case (eng_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    eng_d.op    = cme_op_e'(cmd_op);
                    eng_d.tag   = cmd_addr[ADDR_W-1:IDX_W];
                    eng_d.sdata = cmd_data;
                    if (cmd_op[1]) begin
                        eng_d.idx = cmd_addr[IDX_W-1:0];
                        eng_d.st  = ST_LINE;
                    end else begin
                        eng_d.idx = '0;
                        eng_d.st  = ST_WALK;
                    end
                end
            end
            ST_WALK: begin
                if (eng_q.op == OP_WB_INV && arr_valid && arr_dirty) begin
                    eng_d.maddr = {arr_tag, eng_q.idx};
                    eng_d.mdata = arr_data;
                    eng_d.st    = ST_WB;
                end else begin
                    arr_clr = 1'b1;
                    adv     = 1'b1;
                end
            end
            ST_LINE: begin
                if (eng_q.op == OP_NT_STORE) begin
                    arr_clr     = line_hit;
                    eng_d.maddr = {eng_q.tag, eng_q.idx};
                    eng_d.mdata = eng_q.sdata;
                    eng_d.st    = ST_WB;
                end else if (line_hit_dirty) begin
                    eng_d.maddr = {arr_tag, eng_q.idx};
                    eng_d.mdata = arr_data;
                    eng_d.st    = ST_WB;
                end else begin
                    arr_clr    = line_hit;
                    eng_d.done = 1'b1;
                    eng_d.st   = ST_IDLE;
                end
            end
            ST_WB: begin
                if (mem_ready) begin
                    arr_clr = (eng_q.op != OP_NT_STORE);
                    if (eng_q.op == OP_WB_INV) begin
                        adv = 1'b1;
                    end else begin
                        eng_d.done = 1'b1;
                        eng_d.st   = ST_IDLE;
                    end
                end
            end
            ST_SPC: begin
                if (spc_last) begin
                    eng_d.done = 1'b1;
                    eng_d.st   = ST_IDLE;
                end
            end
            default: eng_d.st = ST_IDLE;
        endcase
        if (adv) begin
            if (eng_q.idx == LAST_IDX) begin
                spc_start = 1'b1;
                spc_wb    = (eng_q.op == OP_WB_INV);
                eng_d.st  = ST_SPC;
            end else begin
                eng_d.idx = eng_q.idx + 1'b1;
                eng_d.st  = ST_WALK;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '{st: ST_IDLE, op: OP_INV_ALL, default: '0};
        else        eng_q <= eng_d;
    end

    always_comb begin
        busy      = (eng_q.st != ST_IDLE);
        cmd_ready = !busy;
        lookup_ok = !busy && !cache_dis;
        done      = eng_q.done;
        arr_idx   = eng_q.idx;
        mem_valid = (eng_q.st == ST_WB);
        mem_addr  = eng_q.maddr;
        mem_data  = eng_q.mdata;
    end

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data)); // R8
    AST_WB_BEFORE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        arr_clr && arr_valid && arr_dirty && (eng_q.op == OP_WB_INV || eng_q.op == OP_FLUSH)
        |-> mem_valid && mem_ready); // R3
    AST_INV_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> eng_q.op != OP_INV_ALL); // R1
    AST_CLR_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        arr_clr |-> busy); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_WHOLE_ENDS_SPC: assert property (@(posedge clk) disable iff (!rst_n)
        done && !eng_q.op[1] |-> $past(spc_code != SPC_NONE)); // R2
    AST_SPC_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        spc_code != SPC_NONE |-> busy); // R11
endmodule

// File: tb/test_cache_maint_engine.sv
module test_cache_maint_engine;
    localparam int N_SPC = 2;
    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_ready;
    logic [1:0] cmd_op = 2'b00;
    logic [7:0] cmd_addr = '0;
    logic [15:0] cmd_data = '0;
    logic [2:0] arr_idx;
    logic arr_valid, arr_dirty, arr_clr;
    logic [4:0] arr_tag;
    logic [15:0] arr_data;
    logic mem_valid, mem_ready = 1'b1;
    logic [7:0] mem_addr;
    logic [15:0] mem_data;
    logic [1:0] spc_code;
    logic cache_dis = 1'b0, lookup_ok, busy, done;

    logic v[8], d[8];
    logic [4:0] tg[8];
    logic [15:0] dat[8];
    logic ev[8];
    logic [7:0] q_addr[$];
    logic [15:0] q_data[$];
    logic [1:0] q_spc[$];
    int total = 0, bad = 0;
    bit stall_en = 0;
    logic [7:0] lfsr = 8'h5a;

    always #10 clk = ~clk;

    cache_maint_engine #(.IDX_W(3), .TAG_W(5), .DATA_W(16), .SPC_CNT(N_SPC)) i_cache_maint_engine (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .arr_idx(arr_idx), .arr_valid(arr_valid),
        .arr_dirty(arr_dirty), .arr_tag(arr_tag), .arr_data(arr_data), .arr_clr(arr_clr),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
        .spc_code(spc_code), .cache_dis(cache_dis), .lookup_ok(lookup_ok), .busy(busy), .done(done));

    assign arr_valid = v[arr_idx];
    assign arr_dirty = d[arr_idx];
    assign arr_tag   = tg[arr_idx];
    assign arr_data  = dat[arr_idx];
    always @(posedge clk) if (arr_clr) begin v[arr_idx] <= 1'b0; d[arr_idx] <= 1'b0; end

    always @(negedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_ready <= stall_en ? lfsr[0] : 1'b1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: pops expected writes and special cycles as they appear
    always begin
        @(negedge clk); #5;
        if (mem_valid && mem_ready) begin
            if (q_addr.size() == 0) chk(0, "R1/R6/R7 unexpected write", mem_addr, -1);
            else begin
                logic [7:0] ea; logic [15:0] ed;
                ea = q_addr.pop_front(); ed = q_data.pop_front();
                chk(mem_addr == ea, "R3/R6/R7 write address", mem_addr, ea);
                chk(mem_data == ed, "R3/R6/R7 write data", mem_data, ed);
            end
        end
        if (spc_code != 2'b00) begin
            if (q_spc.size() == 0) chk(0, "R11 unexpected special cycle", spc_code, 0);
            else begin
                logic [1:0] es;
                es = q_spc.pop_front();
                chk(spc_code == es, "R2/R4 special code", spc_code, es);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic preload(input logic [7:0] vm, input logic [7:0] dm, input logic [4:0] tb);
        for (int i = 0; i < 8; i++) begin
            v[i] = vm[i]; d[i] = dm[i]; tg[i] = tb + 5'(i); dat[i] = 16'h1000 + 16'(i * 17);
            ev[i] = vm[i];
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [7:0] a, input logic [15:0] wd,
                         input bit poke, output int cyc);
        @(negedge clk);
        cmd_op = op; cmd_addr = a; cmd_data = wd; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        cyc = 0;
        while (!done) begin
            if (busy) begin
                cyc++;
                if (cyc == 1) chk(!cmd_ready && !lookup_ok, "R9 ready low while busy", cmd_ready, 0);
                if (poke && cyc == 2) begin cmd_op = 2'b11; cmd_addr = 8'h03; cmd_valid = 1'b1; end
                if (poke && cyc == 3) cmd_valid = 1'b0;
            end
            @(negedge clk);
        end
        chk(!busy, "R9 busy falls with done", busy, 0);
        @(negedge clk);
        chk(!done, "R9 done one cycle", done, 0);
        chk(q_addr.size() == 0 && q_spc.size() == 0, "R3/R4 all expected items seen",
            q_addr.size() + q_spc.size(), 0);
    endtask

    task automatic check_valid(input string req);
        int m = 0;
        for (int i = 0; i < 8; i++) if (v[i] !== ev[i]) m++;
        chk(m == 0, req, m, 0);
    endtask

    initial begin
        int cyc, nd;
        preload(8'h00, 8'h00, 5'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && cmd_ready && !done && !mem_valid, "R9 reset idle", busy, 0);
        chk(spc_code == 2'b00, "R11 reset code", spc_code, 0);
        chk(lookup_ok, "R10 lookup allowed idle", lookup_ok, 1);

        // R1 R2 R5: drop-all loses dirty data
        preload(8'hff, 8'h5a, 5'd4);
        q_spc.push_back(2'b01);
        for (int i = 0; i < 8; i++) ev[i] = 1'b0;
        issue(2'b00, 8'h00, 16'h0, 0, cyc);
        check_valid("R1 all invalid");
        chk(cyc == 9, "R5 drop-all length", cyc, 9);

        // R3 R4 R5: write-back-and-drop, memory always ready
        preload(8'hf7, 8'h2c, 5'd9);
        nd = 0;
        for (int i = 0; i < 8; i++) begin
            if (v[i] && d[i]) begin q_addr.push_back({tg[i], 3'(i)}); q_data.push_back(dat[i]); nd++; end
            ev[i] = 1'b0;
        end
        for (int k = 0; k < N_SPC; k++) q_spc.push_back(2'b10);
        issue(2'b01, 8'h00, 16'h0, 0, cyc);
        check_valid("R3 all invalid");
        chk(cyc == 8 + nd + N_SPC, "R5 write-back length", cyc, 8 + nd + N_SPC);

        // R3 R8 R9: stalled memory, ignored command mid-walk
        stall_en = 1;
        preload(8'hff, 8'hb5, 5'd17);
        for (int i = 0; i < 8; i++) begin
            if (d[i]) begin q_addr.push_back({tg[i], 3'(i)}); q_data.push_back(dat[i]); end
            ev[i] = 1'b0;
        end
        for (int k = 0; k < N_SPC; k++) q_spc.push_back(2'b10);
        issue(2'b01, 8'h00, 16'h0, 1, cyc);
        check_valid("R3 stalled all invalid");
        repeat (3) @(negedge clk);
        chk(!busy, "R9 offered command ignored", busy, 0);
        stall_en = 0;

        // R6: flush dirty hit, clean hit, miss
        preload(8'hff, 8'h0f, 5'd2);
        q_addr.push_back({tg[2], 3'd2}); q_data.push_back(dat[2]);
        ev[2] = 1'b0;
        issue(2'b10, {tg[2], 3'd2}, 16'h0, 0, cyc);
        check_valid("R6 dirty hit only target cleared");
        ev[5] = 1'b0;
        issue(2'b10, {tg[5], 3'd5}, 16'h0, 0, cyc);
        check_valid("R6 clean hit cleared");
        issue(2'b10, {tg[6] + 5'd1, 3'd6}, 16'h0, 0, cyc);
        check_valid("R6 miss unchanged");

        // R7: non-temporal store miss then dirty hit
        q_addr.push_back({5'd30, 3'd1}); q_data.push_back(16'hbeef);
        issue(2'b11, {5'd30, 3'd1}, 16'hbeef, 0, cyc);
        check_valid("R7 miss no allocate");
        chk(tg[1] == 5'd3 && dat[1] == 16'h1011, "R7 line untouched", tg[1], 3);
        q_addr.push_back({tg[3], 3'd3}); q_data.push_back(16'hcafe);
        ev[3] = 1'b0;
        issue(2'b11, {tg[3], 3'd3}, 16'hcafe, 0, cyc);
        check_valid("R7 hit invalidated");

        // R10
        cache_dis = 1'b1;
        @(negedge clk);
        chk(!lookup_ok, "R10 disabled", lookup_ok, 0);
        cache_dis = 1'b0;
        @(negedge clk);
        chk(lookup_ok, "R10 re-enabled", lookup_ok, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule